// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words on a three-wire serial port (data, shift clock, load strobe) and places each word into one of two holding registers. The last bit shifted into a word is a routing bit. When that bit is 1 and the load strobe is high, the word goes to the reference register. This register is 15 bits wide and holds a 14-bit reference ratio and a prescaler select bit. When the routing bit is 0, the word goes to the divider register. This register is 18 bits wide and holds a 7-bit swallow value and an 11-bit counter value.

All logic runs on the oscillator clock `clk`. The serial clock, data and load strobe are each passed through a two-stage synchronizer. A shift happens on each detected rising edge of the synchronized serial clock. The serial clock must therefore toggle slower than a quarter of `clk`. The block also holds the programmable reference counter. This counter divides `clk` by the stored ratio and emits one pulse on `fr` for each period. A new ratio is picked up at the next terminal count. A reference ratio below 6 is not allowed: such a word is dropped as a whole.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts one bit of `ser_data` into the shift register. Words are sent MSB first, and the routing bit is sent last.
- R2: A word whose routing bit is 1 goes to the reference register while `ser_le` is high. The divider register does not change.
- R3: A word whose routing bit is 0 goes to the divider register while `ser_le` is high. The reference register does not change.
- R4: A reference word is 16 bits long. The first bit sent is the prescaler select. The next 14 bits are the ratio, from its bit 13 down to its bit 0. The routing bit comes last.
- R5: A divider word is 19 bits long. The first 11 bits sent are the counter value, MSB first. The next 7 bits are the swallow value, MSB first. The routing bit comes last.
- R6: A reference word whose ratio is below 6 is rejected. The stored ratio and prescaler select both keep their old values, so the stored ratio is never below 6.
- R7: While `ser_le` is low, neither register changes, even when bits are being shifted.
- R8: `fr` is high for exactly one `clk` cycle every R cycles, where R is the stored ratio.
- R9: At the terminal count, the reference counter reloads from the stored ratio. A new ratio therefore sets the spacing from the first `fr` pulse after the update onward.
- R10: After reset, the ratio is 16383, the prescaler select is 1, the swallow and counter values are 0, and `fr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; clocks all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; level-sensitive transfer while high |
| ref_ratio | output | 14 | Stored reference ratio |
| presc_sel | output | 1 | Stored prescaler select bit |
| swallow_val | output | 7 | Stored swallow value |
| count_val | output | 11 | Stored counter value |
| fr | output | 1 | Reference pulse, one clock wide, every ratio cycles |

## Verification
The bench sweeps every legal ratio from 6 to 40 and measures the `fr` spacing after each update. A counter that reloads one cycle early or late, or reloads from a stale ratio, shows up as a wrong interval. Every prohibited ratio from 0 to 5 is sent, and the bench checks that both reference fields keep their old values. A design that checks the limit off by one, or that still writes the select bit of a rejected word, fails here. Divider words with varied bit patterns check the field positions and show that the routing bit protects the other register. A word shifted in with the strobe low must leave both registers unchanged. The largest ratio checks that the top counter bit is wired through.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  parameter int REF_W    = 14;
  parameter int SWL_W    = 7;
  parameter int CNT_W    = 11;
  parameter int MIN_REF  = 6;
  parameter int REF_INIT = 16383;
  parameter bit SEL_INIT = 1'b1;

  localparam int REF_WORD = REF_W + 2;
  localparam int DIV_WORD = SWL_W + CNT_W + 1;
  localparam int SR_W     = (REF_WORD > DIV_WORD) ? REF_WORD : DIV_WORD;

  typedef struct packed {
    logic             sel;
    logic [REF_W-1:0] ratio;
  } ref_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [SWL_W-1:0] swallow;
  } div_cfg_t;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter
  import cfg_ldr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            din_s,
  output logic            shift_en,
  output logic [SR_W-1:0] sr
);
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;

  assign shift_en = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-2:0], din_s};

  AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr[0] == $past(din_s)) && (sr[SR_W-1:1] == $past(sr[SR_W-2:0]))); // R1
  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr)); // R1
endmodule

// File: rtl/sl_latches.sv
module sl_latches
  import cfg_ldr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            le_s,
  input  logic [SR_W-1:0] sr,
  output ref_cfg_t        ref_q,
  output div_cfg_t        div_q
);
  function automatic logic ratio_legal(input logic [REF_W-1:0] r);
    return r >= REF_W'(MIN_REF);
  endfunction

  ref_cfg_t ref_word;
  div_cfg_t div_word;
  logic     route_ref;
  logic     ref_wr, div_wr, ref_reject;

  assign route_ref  = sr[0];
  assign ref_word   = sr[REF_WORD-1:1];
  assign div_word   = sr[DIV_WORD-1:1];
  assign ref_wr     = le_s &  route_ref & ratio_legal(ref_word.ratio);
  assign ref_reject = le_s &  route_ref & ~ratio_legal(ref_word.ratio);
  assign div_wr     = le_s & ~route_ref;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ref_q <= '{sel: SEL_INIT, ratio: REF_W'(REF_INIT)};
    else if (ref_wr) ref_q <= ref_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= div_word;

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q.ratio >= REF_W'(MIN_REF)); // R6
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_reject |=> $stable(ref_q)); // R6
  AST_LE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> ($stable(ref_q) && $stable(div_q))); // R7
  AST_DIV_ROUTE_SPARES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && !route_ref) |=> $stable(ref_q)); // R3
  AST_REF_ROUTE_SPARES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && route_ref) |=> $stable(div_q)); // R2
endmodule

// File: rtl/sl_refcnt.sv
module sl_refcnt
  import cfg_ldr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ratio,
  output logic             fr
);
  logic [REF_W-1:0] cnt;
  logic             term;

  function automatic logic [REF_W-1:0] count_next(input logic [REF_W-1:0] c,
                                                  input logic [REF_W-1:0] r);
    return (c == REF_W'(1)) ? r : c - REF_W'(1);
  endfunction

  assign term = (cnt == REF_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= REF_W'(REF_INIT);
      fr  <= 1'b0;
    end else begin
      cnt <= count_next(cnt, ratio);
      fr  <= term;
    end

  AST_FR_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    fr |=> !fr); // R8
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0); // R8
  AST_RELOAD_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    fr |-> (cnt == $past(ratio))); // R9
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_ldr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [REF_W-1:0] ref_ratio,
  output logic             presc_sel,
  output logic [SWL_W-1:0] swallow_val,
  output logic [CNT_W-1:0] count_val,
  output logic             fr
);
  logic [2:0]      sync_q;
  logic            sclk_s, din_s, le_s, shift_en;
  logic [SR_W-1:0] sr;
  ref_cfg_t        ref_q;
  div_cfg_t        div_q;

  sl_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_le, ser_data, ser_clk}), .q(sync_q)
  );
  assign {le_s, din_s, sclk_s} = sync_q;

  sl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .din_s(din_s),
    .shift_en(shift_en), .sr(sr)
  );

  sl_latches u_latch (
    .clk(clk), .rst_n(rst_n), .le_s(le_s), .sr(sr),
    .ref_q(ref_q), .div_q(div_q)
  );

  sl_refcnt u_refcnt (
    .clk(clk), .rst_n(rst_n), .ratio(ref_q.ratio), .fr(fr)
  );

  assign ref_ratio   = ref_q.ratio;
  assign presc_sel   = ref_q.sel;
  assign swallow_val = div_q.swallow;
  assign count_val   = div_q.count;

  AST_RESET_FR_LOW: assert property (@(posedge clk)
    !rst_n |=> !fr); // R10
endmodule

// File: tb/serial_cfg_loader_bench.sv
module serial_cfg_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic        presc_sel;
  logic [6:0]  swallow_val;
  logic [10:0] count_val;
  logic        fr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_cfg_loader u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
    .swallow_val(swallow_val), .count_val(count_val), .fr(fr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_le = 1'b1;
    repeat (4) @(negedge clk); ser_le = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // reference word: select first, ratio MSB..LSB, routing bit 1 last
  task automatic send_ref(input int ratio, input bit sel);
    shift_bits({15'd0, sel, ratio[13:0], 1'b1}, 16);
    strobe();
  endtask

  // divider word: counter MSB first, swallow, routing bit 0 last
  task automatic send_div(input int cnt, input int swl);
    shift_bits({13'd0, cnt[10:0], swl[6:0], 1'b0}, 19);
    strobe();
  endtask

  task automatic period(output int p);
    int guard = 0;
    while (!fr && guard < 40000) begin @(negedge clk); guard++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!fr && p < 40000);
  endtask

  initial begin
    int p;
    int keep_r;
    bit keep_s;
    repeat (3) @(negedge clk);
    check("R10 ratio", ref_ratio, 16383);
    check("R10 sel", presc_sel, 1);
    check("R10 swallow", swallow_val, 0);
    check("R10 count", count_val, 0);
    check("R10 fr", fr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4 R8 R9: sweep of small legal ratios
    for (int r = 6; r <= 40; r++) begin
      send_ref(r, r[0]);
      check("R4 ratio field", ref_ratio, r);
      check("R2 sel field", presc_sel, r & 1);
      period(p);
      period(p);
      check("R8 R9 fr spacing", p, r);
    end

    // R6: every prohibited ratio leaves the whole register alone
    keep_r = ref_ratio;
    keep_s = presc_sel;
    for (int r = 0; r < 6; r++) begin
      send_ref(r, !keep_s);
      check("R6 ratio kept", ref_ratio, keep_r);
      check("R6 sel kept", presc_sel, keep_s);
    end
    period(p); period(p);
    check("R6 spacing kept", p, keep_r);

    // R1 R3 R5: divider patterns
    for (int i = 0; i < 16; i++) begin
      int c, s;
      c = (i * 301 + 16) & 2047;
      s = (i * 37 + 5) & 127;
      send_div(c, s);
      check("R5 R1 count field", count_val, c);
      check("R5 swallow field", swallow_val, s);
      check("R3 ratio untouched", ref_ratio, keep_r);
    end
    send_div(2047, 127);
    check("R5 count all ones", count_val, 2047);
    send_ref(9, 1'b0);
    check("R2 swallow untouched", swallow_val, 127);
    check("R2 ratio after divider", ref_ratio, 9);

    // R7: shifting with the strobe low changes nothing
    shift_bits({13'd0, 11'd5, 7'd3, 1'b0}, 19);
    repeat (6) @(negedge clk);
    check("R7 count held", count_val, 2047);
    check("R7 swallow held", swallow_val, 127);
    shift_bits({15'd0, 1'b1, 14'd77, 1'b1}, 16);
    repeat (6) @(negedge clk);
    check("R7 ratio held", ref_ratio, 9);
    strobe();
    check("R7 ratio after strobe", ref_ratio, 77);

    // R8: largest ratio
    send_ref(16383, 1'b1);
    check("R4 max ratio", ref_ratio, 16383);
    period(p); period(p);
    check("R8 max spacing", p, 16383);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule